// File: doc/BRIEF.md
# Register-Format Integer Execute Unit

This block is the execute stage for register-to-register integer instructions. Each accepted instruction word carries a 6-bit function code in bits 5:0, a constant shift amount in bits 10:6 and a destination index in bits 15:11. The two source operand values, already read for the fields at bits 25:21 (first source) and 20:16 (second source), arrive beside it. The unit computes one of fifteen operations: constant and variable shifts (logical left, logical right, arithmetic right), wrapped add and subtract, four bitwise functions, and signed or unsigned set-less-than. It registers the result together with the destination index and a write enable.

A function code outside the supported set is reported on `illegal` and never produces a write. A destination index of zero also suppresses the write, so architectural register zero stays zero. A two-state output machine tracks whether the output register holds fresh data. It moves from OUT_IDLE to OUT_LIVE on an issue (in_valid high). It stays in OUT_LIVE on back-to-back issues and drains back to OUT_IDLE on any cycle without in_valid.

Top module: `rfx_exec_unit`

## Requirements
- R1: While reset is held, out_valid, wr_en and illegal read 0 and result reads 0.
- R2: An instruction accepted with in_valid high appears one clock later with out_valid high, and dest_idx equals instruction bits 15:11.
- R3: Function 0 shifts the second operand left and function 2 shifts it right with zero fill, both by the amount in instruction bits 10:6.
- R4: Function 3 (constant amount) and function 7 (amount from the first operand) shift the second operand right, filling vacated bits with its bit 31. A shift amount of zero returns the second operand unchanged.
- R5: Functions 4, 6 and 7 take the shift amount from bits 4:0 of the first operand and ignore its upper bits. Function 4 shifts left and function 6 shifts right logically.
- R6: Functions 32 and 33 both give the 32-bit sum wrapped modulo 2^32, with no overflow indication. Function 35 gives first operand minus second operand, wrapped.
- R7: Functions 36, 37, 38 and 39 give AND, OR, XOR and NOT-of-OR of the two operands respectively.
- R8: Function 42 writes 1 when the first operand is less than the second as signed two's-complement values, else 0. Function 43 does the same comparison unsigned.
- R9: Any other function code gives illegal = 1, wr_en = 0 and result = 0 with out_valid high.
- R10: A legal instruction with destination index 0 gives wr_en = 0, while result still carries the computed value.
- R11: A cycle without in_valid gives out_valid, wr_en and illegal of 0 on the next cycle, and result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue strobe for the instruction on `instr` |
| instr | input | 32 | Instruction word; bits 5:0 function, 10:6 shift amount, 15:11 destination |
| opnd_a | input | XLEN | Value of the first source register |
| opnd_b | input | XLEN | Value of the second source register |
| out_valid | output | 1 | Output register holds a result issued one cycle earlier |
| result | output | XLEN | Computed value |
| dest_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register write request, valid with out_valid |
| illegal | output | 1 | Issued function code is not supported |

## Verification
The bench builds the unit at its default width, XLEN = 32. At that width every constant and register-sourced shift amount from 0 through 31 and the sign boundary at bit 31 can be reached, and so can wrap-around in the adder. Random operands drawn with a fixed seed hit all fifteen function codes and the unused codes between them. Directed cases add the extremes: shift by 31 of a negative value, shift by zero, register amounts with noisy upper bits, signed against unsigned comparison across the sign bit, destination zero, and idle gaps between issues.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

    localparam int unsigned INSTR_W    = 32;
    localparam int unsigned FUNC_W     = 6;
    localparam int unsigned IDX_W      = 5;
    localparam int unsigned SHAMT_W    = 5;
    localparam int unsigned FUNC_LSB   = 0;
    localparam int unsigned SHAMT_LSB  = 6;
    localparam int unsigned DEST_LSB   = 11;

    // function codes whose values the decoder must honour
    localparam logic [FUNC_W-1:0] FN_SLL  = 6'd0;
    localparam logic [FUNC_W-1:0] FN_SRL  = 6'd2;
    localparam logic [FUNC_W-1:0] FN_SRA  = 6'd3;
    localparam logic [FUNC_W-1:0] FN_SLLV = 6'd4;
    localparam logic [FUNC_W-1:0] FN_SRLV = 6'd6;
    localparam logic [FUNC_W-1:0] FN_SRAV = 6'd7;
    localparam logic [FUNC_W-1:0] FN_ADD  = 6'd32;
    localparam logic [FUNC_W-1:0] FN_ADDU = 6'd33;
    localparam logic [FUNC_W-1:0] FN_SUBU = 6'd35;
    localparam logic [FUNC_W-1:0] FN_AND  = 6'd36;
    localparam logic [FUNC_W-1:0] FN_OR   = 6'd37;
    localparam logic [FUNC_W-1:0] FN_XOR  = 6'd38;
    localparam logic [FUNC_W-1:0] FN_NOR  = 6'd39;
    localparam logic [FUNC_W-1:0] FN_SLT  = 6'd42;
    localparam logic [FUNC_W-1:0] FN_SLTU = 6'd43;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_SHL,
        OP_SHR_LOG,
        OP_SHR_ARI,
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_XOR,
        OP_NOR,
        OP_LT_S,
        OP_LT_U
    } op_e;

    typedef enum logic {
        AMT_FIELD,
        AMT_REG
    } amt_src_e;

    typedef struct packed {
        op_e      op;
        amt_src_e amt_src;
        logic     is_shift;
        logic     illegal;
    } dec_t;

    typedef enum logic {
        OUT_IDLE,
        OUT_LIVE
    } out_state_e;

endpackage

// File: rtl/rfx_decoder.sv
module rfx_decoder
    import rfx_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    output dec_t              dec
);

    always_comb begin
        dec = '{op: OP_NONE, amt_src: AMT_FIELD, is_shift: 1'b0, illegal: 1'b1};
        unique case (func)
            FN_SLL:  dec = '{op: OP_SHL,     amt_src: AMT_FIELD, is_shift: 1'b1, illegal: 1'b0};
            FN_SRL:  dec = '{op: OP_SHR_LOG, amt_src: AMT_FIELD, is_shift: 1'b1, illegal: 1'b0};
            FN_SRA:  dec = '{op: OP_SHR_ARI, amt_src: AMT_FIELD, is_shift: 1'b1, illegal: 1'b0};
            FN_SLLV: dec = '{op: OP_SHL,     amt_src: AMT_REG,   is_shift: 1'b1, illegal: 1'b0};
            FN_SRLV: dec = '{op: OP_SHR_LOG, amt_src: AMT_REG,   is_shift: 1'b1, illegal: 1'b0};
            FN_SRAV: dec = '{op: OP_SHR_ARI, amt_src: AMT_REG,   is_shift: 1'b1, illegal: 1'b0};
            FN_ADD,
            FN_ADDU: dec = '{op: OP_ADD,     amt_src: AMT_FIELD, is_shift: 1'b0, illegal: 1'b0};
            FN_SUBU: dec = '{op: OP_SUB,     amt_src: AMT_FIELD, is_shift: 1'b0, illegal: 1'b0};
            FN_AND:  dec = '{op: OP_AND,     amt_src: AMT_FIELD, is_shift: 1'b0, illegal: 1'b0};
            FN_OR:   dec = '{op: OP_OR,      amt_src: AMT_FIELD, is_shift: 1'b0, illegal: 1'b0};
            FN_XOR:  dec = '{op: OP_XOR,     amt_src: AMT_FIELD, is_shift: 1'b0, illegal: 1'b0};
            FN_NOR:  dec = '{op: OP_NOR,     amt_src: AMT_FIELD, is_shift: 1'b0, illegal: 1'b0};
            FN_SLT:  dec = '{op: OP_LT_S,    amt_src: AMT_FIELD, is_shift: 1'b0, illegal: 1'b0};
            FN_SLTU: dec = '{op: OP_LT_U,    amt_src: AMT_FIELD, is_shift: 1'b0, illegal: 1'b0};
            default: dec = '{op: OP_NONE,    amt_src: AMT_FIELD, is_shift: 1'b0, illegal: 1'b1};
        endcase
    end

endmodule

// File: rtl/rfx_shifter.sv
// Logarithmic right shifter; left shifts reuse it by bit reversal.
module rfx_shifter #(
    parameter int unsigned W  = 32,
    parameter int unsigned SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          dir_left,
    input  logic          arith,
    output logic [W-1:0]  dout
);

    logic [W-1:0] din_rev;
    logic [W-1:0] core_in;
    logic [W-1:0] core_out;
    logic [W-1:0] core_rev;
    logic [W-1:0] stage [0:SW];
    logic         fill;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign din_rev[i]  = din[W-1-i];
        assign core_rev[i] = core_out[W-1-i];
    end

    assign core_in  = dir_left ? din_rev : din;
    assign fill     = arith && !dir_left && din[W-1];
    assign stage[0] = core_in;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int unsigned STEP = 1 << s;
        assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][W-1:STEP]} : stage[s];
    end

    assign core_out = stage[SW];
    assign dout     = dir_left ? core_rev : core_out;

endmodule

// File: rtl/rfx_alu.sv
// Shared adder serves add and subtract; signed compare derives from unsigned.
module rfx_alu
    import rfx_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    output logic [W-1:0] res
);

    logic         do_sub;
    logic [W-1:0] b_eff;
    logic [W-1:0] sum;
    logic         lt_u;
    logic         lt_s;

    assign do_sub = (op == OP_SUB);
    assign b_eff  = do_sub ? ~b : b;
    assign sum    = a + b_eff + {{(W-1){1'b0}}, do_sub};
    assign lt_u   = (a < b);
    assign lt_s   = (a[W-1] != b[W-1]) ? a[W-1] : lt_u;

    always_comb begin
        res = '0;
        unique case (op)
            OP_ADD,
            OP_SUB:  res = sum;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOR:  res = ~(a | b);
            OP_LT_S: res = {{(W-1){1'b0}}, lt_s};
            OP_LT_U: res = {{(W-1){1'b0}}, lt_u};
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/rfx_exec_unit.sv
module rfx_exec_unit
    import rfx_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [XLEN-1:0]    opnd_a,
    input  logic [XLEN-1:0]    opnd_b,
    output logic               out_valid,
    output logic [XLEN-1:0]    result,
    output logic [IDX_W-1:0]   dest_idx,
    output logic               wr_en,
    output logic               illegal
);

    localparam int unsigned SHW = $clog2(XLEN);

    dec_t             dec;
    logic [FUNC_W-1:0] func;
    logic [IDX_W-1:0]  rd;
    logic [SHW-1:0]    amt_field;
    logic [SHW-1:0]    amt;
    logic [XLEN-1:0]   shift_res;
    logic [XLEN-1:0]   alu_res;
    logic [XLEN-1:0]   exec_res;
    out_state_e        state_q;
    out_state_e        state_d;
    logic              unused_fields;

    assign func          = instr[FUNC_LSB +: FUNC_W];
    assign rd            = instr[DEST_LSB +: IDX_W];
    assign amt_field     = SHW'(instr[SHAMT_LSB +: SHAMT_W]);
    assign unused_fields = ^instr[INSTR_W-1:DEST_LSB+IDX_W];

    rfx_decoder u_dec (
        .func (func),
        .dec  (dec)
    );

    assign amt = (dec.amt_src == AMT_REG) ? opnd_a[SHW-1:0] : amt_field;

    rfx_shifter #(
        .W  (XLEN),
        .SW (SHW)
    ) u_shift (
        .din      (opnd_b),
        .amt      (amt),
        .dir_left (dec.op == OP_SHL),
        .arith    (dec.op == OP_SHR_ARI),
        .dout     (shift_res)
    );

    rfx_alu #(
        .W (XLEN)
    ) u_alu (
        .a   (opnd_a),
        .b   (opnd_b),
        .op  (dec.op),
        .res (alu_res)
    );

    always_comb begin
        if (dec.illegal) begin
            exec_res = '0;
        end else if (dec.is_shift) begin
            exec_res = shift_res;
        end else begin
            exec_res = alu_res;
        end
    end

    // next-state logic: issue enters OUT_LIVE, an empty cycle drains to OUT_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE: state_d = in_valid ? OUT_LIVE : OUT_IDLE;
            OUT_LIVE: state_d = in_valid ? OUT_LIVE : OUT_IDLE;
            default:  state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            dest_idx <= '0;
            wr_en    <= 1'b0;
            illegal  <= 1'b0;
        end else if (in_valid) begin
            result   <= exec_res;
            dest_idx <= rd;
            wr_en    <= !dec.illegal && (rd != '0);
            illegal  <= dec.illegal;
        end else begin
            wr_en    <= 1'b0;
            illegal  <= 1'b0;
        end
    end

    assign out_valid = (state_q == OUT_LIVE);

endmodule

// File: rtl/rfx_exec_unit_chk.sv
module rfx_exec_unit_chk
    import rfx_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [INSTR_W-1:0] instr,
    input logic [XLEN-1:0]    opnd_b,
    input logic               out_valid,
    input logic [XLEN-1:0]    result,
    input logic [IDX_W-1:0]   dest_idx,
    input logic               wr_en,
    input logic               illegal
);

    AST_ISSUE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_DEST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (dest_idx == $past(instr[DEST_LSB +: IDX_W]))); // R2

    AST_SRA_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[FUNC_LSB +: FUNC_W] == FN_SRA && instr[SHAMT_LSB +: SHAMT_W] == '0)
        |=> (result == $past(opnd_b))); // R4

    AST_LT_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (instr[FUNC_LSB +: FUNC_W] == FN_SLT || instr[FUNC_LSB +: FUNC_W] == FN_SLTU))
        |=> (result[XLEN-1:1] == '0)); // R8

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && result == '0 && out_valid)); // R9

    AST_ZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dest_idx == '0) |-> !wr_en); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en && !illegal)); // R11

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R11

endmodule

bind rfx_exec_unit rfx_exec_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .opnd_b    (opnd_b),
    .out_valid (out_valid),
    .result    (result),
    .dest_idx  (dest_idx),
    .wr_en     (wr_en),
    .illegal   (illegal)
);

// File: tb/rfx_exec_unit_bench.sv
`timescale 1ns/1ps
module rfx_exec_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [4:0]  dest_idx;
    logic        wr_en;
    logic        illegal;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] last_result = '0;

    always #10 clk = ~clk;

    rfx_exec_unit u_rfx_exec_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .instr     (instr),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .out_valid (out_valid),
        .result    (result),
        .dest_idx  (dest_idx),
        .wr_en     (wr_en),
        .illegal   (illegal)
    );

    // expected {illegal, value} computed from the requirements
    function automatic logic [32:0] model(input logic [31:0] ins, input logic [31:0] a,
                                          input logic [31:0] b);
        logic [4:0]  sh;
        logic [4:0]  vs;
        logic [31:0] r;
        logic        bad;
        sh  = ins[10:6];
        vs  = a[4:0];
        r   = '0;
        bad = 1'b0;
        case (ins[5:0])
            6'd0:  r = b << sh;
            6'd2:  r = b >> sh;
            6'd3:  r = $unsigned($signed(b) >>> sh);
            6'd4:  r = b << vs;
            6'd6:  r = b >> vs;
            6'd7:  r = $unsigned($signed(b) >>> vs);
            6'd32, 6'd33: r = a + b;
            6'd35: r = a - b;
            6'd36: r = a & b;
            6'd37: r = a | b;
            6'd38: r = a ^ b;
            6'd39: r = ~(a | b);
            6'd42: r = {31'd0, ($signed(a) < $signed(b))};
            6'd43: r = {31'd0, (a < b)};
            default: bad = 1'b1;
        endcase
        return {bad, r};
    endfunction

    function automatic logic [31:0] mk(input logic [5:0] fn, input logic [4:0] rd,
                                       input logic [4:0] sh);
        return {6'd0, 5'd0, 5'd0, rd, sh, fn};
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic run_op(input string tag, input logic [31:0] ins, input logic [31:0] a,
                          input logic [31:0] b);
        logic [32:0] m;
        m        = model(ins, a, b);
        in_valid = 1'b1;
        instr    = ins;
        opnd_a   = a;
        opnd_b   = b;
        @(negedge clk);
        check(tag, "result", result, m[31:0]);
        check(tag, "illegal", {31'd0, illegal}, {31'd0, m[32]});
        check(tag, "wr_en", {31'd0, wr_en}, {31'd0, (!m[32] && ins[15:11] != 5'd0)});
        check("R2", "out_valid", {31'd0, out_valid}, 32'd1);
        check("R2", "dest_idx", {27'd0, dest_idx}, {27'd0, ins[15:11]});
        last_result = m[31:0];
    endtask

    task automatic idle_cycle();
        in_valid = 1'b0;
        instr    = $urandom();
        opnd_a   = $urandom();
        opnd_b   = $urandom();
        @(negedge clk);
        check("R11", "out_valid", {31'd0, out_valid}, 32'd0);
        check("R11", "wr_en", {31'd0, wr_en}, 32'd0);
        check("R11", "illegal", {31'd0, illegal}, 32'd0);
        check("R11", "result hold", result, last_result);
    endtask

    localparam logic [5:0] LEGAL [15] = '{6'd0, 6'd2, 6'd3, 6'd4, 6'd6, 6'd7, 6'd32,
                                          6'd33, 6'd35, 6'd36, 6'd37, 6'd38, 6'd39,
                                          6'd42, 6'd43};

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        check("R1", "out_valid", {31'd0, out_valid}, 32'd0);
        check("R1", "wr_en", {31'd0, wr_en}, 32'd0);
        check("R1", "illegal", {31'd0, illegal}, 32'd0);
        check("R1", "result", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 constant shifts
        run_op("R3", mk(6'd0, 5'd3, 5'd4), 32'h0, 32'h8000_00F1);
        run_op("R3", mk(6'd2, 5'd3, 5'd31), 32'h0, 32'h8000_0000);
        run_op("R3", mk(6'd2, 5'd9, 5'd0), 32'h0, 32'hDEAD_BEEF);
        // R4 sign fill, zero amount
        run_op("R4", mk(6'd3, 5'd1, 5'd31), 32'h0, 32'h8000_0000);
        run_op("R4", mk(6'd3, 5'd1, 5'd0), 32'h0, 32'h9234_5678);
        run_op("R4", mk(6'd3, 5'd1, 5'd8), 32'h0, 32'h7234_5678);
        run_op("R4", mk(6'd7, 5'd2, 5'd0), 32'hFFFF_FFE5, 32'h8000_0000);
        run_op("R4", mk(6'd7, 5'd2, 5'd17), 32'h0000_0020, 32'hF000_000F);
        // R5 register-sourced amounts with noisy upper bits
        run_op("R5", mk(6'd4, 5'd4, 5'd9), 32'hFFFF_FFE1, 32'h0000_0003);
        run_op("R5", mk(6'd6, 5'd4, 5'd2), 32'h1234_567F, 32'hFFFF_FFFF);
        // R6 wrap
        run_op("R6", mk(6'd32, 5'd5, 5'd0), 32'h7FFF_FFFF, 32'h0000_0001);
        run_op("R6", mk(6'd33, 5'd5, 5'd0), 32'hFFFF_FFFF, 32'h0000_0002);
        run_op("R6", mk(6'd35, 5'd5, 5'd0), 32'h0000_0000, 32'h0000_0001);
        // R7 logic
        run_op("R7", mk(6'd36, 5'd6, 5'd0), 32'hF0F0_1234, 32'hFF00_FF00);
        run_op("R7", mk(6'd37, 5'd6, 5'd0), 32'hF0F0_1234, 32'h0F00_FF00);
        run_op("R7", mk(6'd38, 5'd6, 5'd0), 32'hAAAA_5555, 32'hFFFF_0000);
        run_op("R7", mk(6'd39, 5'd6, 5'd0), 32'h0, 32'h0);
        // R8 compares across the sign bit
        run_op("R8", mk(6'd42, 5'd7, 5'd0), 32'h8000_0000, 32'h0000_0001);
        run_op("R8", mk(6'd43, 5'd7, 5'd0), 32'h8000_0000, 32'h0000_0001);
        run_op("R8", mk(6'd42, 5'd7, 5'd0), 32'h0000_0005, 32'h0000_0005);
        run_op("R8", mk(6'd43, 5'd7, 5'd0), 32'h0000_0004, 32'hFFFF_FFFF);
        // R9 unused codes
        run_op("R9", mk(6'd1, 5'd8, 5'd3), 32'h1, 32'h2);
        run_op("R9", mk(6'd34, 5'd8, 5'd0), 32'h1, 32'h2);
        run_op("R9", mk(6'd63, 5'd8, 5'd0), 32'h1, 32'h2);
        run_op("R9", mk(6'd40, 5'd0, 5'd0), 32'h1, 32'h2);
        // R10 destination zero
        run_op("R10", mk(6'd33, 5'd0, 5'd0), 32'h0000_1000, 32'h0000_0234);
        run_op("R10", mk(6'd0, 5'd0, 5'd1), 32'h0, 32'h4000_0001);
        idle_cycle();
        idle_cycle();

        // random mix, fixed seed
        for (int k = 0; k < 600; k++) begin
            logic [5:0]  fn;
            logic [31:0] ins;
            if (($urandom() % 100) < 85) begin
                fn = LEGAL[$urandom() % 15];
            end else begin
                fn = 6'($urandom());
            end
            ins = $urandom();
            ins[31:26] = 6'd0;
            ins[5:0]   = fn;
            run_op("R6/R3 random", ins, $urandom(), $urandom());
            if (($urandom() % 10) == 0) begin
                idle_cycle();
            end
        end
        idle_cycle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule